// File: doc/BRIEF.md
# Timer Compare/Capture Channel Controller

This block is one channel of a timer. It takes a free-running counter value from outside and owns two general registers, A and B. An 8-bit control register holds one 4-bit mode field per general register. Each field makes its register either an output-compare register or an input-capture register.

In output-compare mode the register drives a pin. The pin is set to a chosen starting level when the mode is written. On each compare match the pin is then cleared, set or toggled. In input-capture mode the register latches the counter value. The trigger is either a selected edge of a dedicated input pin or a count event from the neighbouring channel. The neighbour trigger is ignored while that neighbour counts at the undivided clock, which the neighbour reports as prescaler select zero.

Software writes the control register and both general registers through one write port. The current contents can be read back on output ports.

Top module: `tcc_channel`

## Requirements
- R1: The control register resets to 0x00. A write with `wr_sel`=0 loads `wr_data[7:0]` on the next edge. Bits 3:0 are the mode field of register A and bits 7:4 are the mode field of register B.
- R2: Writing a field whose bit 3 is 0 (compare mode) drives that register's pin output, on the same edge, to the level given by field bit 2.
- R3: A pin enable is high only when the field's bit 3 is 0 and its bits 1:0 are not 00. It is low in every capture mode.
- R4: In compare mode, a clock edge with `cnt_en`=1 and `cnt_val` equal to the general register applies the action in bits 1:0 to the pin on that edge: 01 drives 0, 10 drives 1, 11 inverts, 00 leaves the level unchanged. Without `cnt_en` nothing happens.
- R5: Field value 10xx captures `cnt_val` on an edge of the register's input pin. Bits 1:0 select the edge: 00 rising, 01 falling, 1x both. The pin passes through two synchroniser stages, so the capture occurs on the third clock edge after the pin changes.
- R6: Field value 11xx captures `cnt_val` on every edge where `nb_cnt_evt`=1 and `nb_psc` is not zero.
- R7: In field value 11xx a neighbour event while `nb_psc`=000 leaves the general register unchanged.
- R8: When a capture and a software write to the same general register fall on one edge, the captured counter value is stored.
- R9: In any capture mode the pin output keeps its last level.
- R10: The general registers reset to 0. `wr_sel`=1 writes A and `wr_sel`=2 writes B from `wr_data` on the next edge, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 register A, 2 register B |
| wr_data | input | CNT_W | Write data |
| cnt_val | input | CNT_W | Counter value |
| cnt_en | input | 1 | Counter advance qualifier for compare |
| nb_psc | input | PSC_W | Neighbour prescaler select |
| nb_cnt_evt | input | 1 | Neighbour count-up/down event |
| pin_a_in | input | 1 | Capture input pin for register A |
| pin_b_in | input | 1 | Capture input pin for register B |
| ctrl_q | output | 8 | Control register contents |
| gr_a | output | CNT_W | General register A |
| gr_b | output | CNT_W | General register B |
| pin_a_out | output | 1 | Pin level for register A |
| pin_a_oe | output | 1 | Pin enable for register A |
| pin_b_out | output | 1 | Pin level for register B |
| pin_b_oe | output | 1 | Pin enable for register B |

## Verification
A capture and a software write can land on the same general register in the same cycle. The bench provokes this by putting register A in neighbour-capture mode and asserting a qualified neighbour event in the same cycle as a write to A. It judges the result by reading back `gr_a` and expecting the counter value, not the written data. A second same-cycle case is a mode-entry write arriving while the counter matches. The checker covers it by requiring that the entry level wins.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_TOG  = 2'b11
   } tcc_act_e;

   typedef enum logic [1:0] {
      SRC_CMP = 2'd0,
      SRC_PIN = 2'd1,
      SRC_NB  = 2'd2
   } tcc_src_e;

   typedef struct packed {
      tcc_src_e   src;
      tcc_act_e   act;
      logic       init_lvl;
      logic [1:0] edge_sel;
   } tcc_mode_t;

   localparam int FIELD_W = 4;
   localparam int NUM_GR  = 2;
   localparam int CTRL_W  = FIELD_W * NUM_GR;

   function automatic tcc_mode_t tcc_decode(input logic [FIELD_W-1:0] f);
      tcc_mode_t m;
      if (!f[3])
         m.src = SRC_CMP;
      else if (f[2])
         m.src = SRC_NB;
      else
         m.src = SRC_PIN;
      m.act      = tcc_act_e'(f[1:0]);
      m.init_lvl = f[2];
      m.edge_sel = f[1:0];
      return m;
   endfunction

endpackage

// File: rtl/tcc_ctrl_reg.sv
module tcc_ctrl_reg
   import tcc_pkg::*;
#(
   parameter int W = CTRL_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr)
         q <= din;
   end

endmodule

// File: rtl/tcc_nb_gate.sv
module tcc_nb_gate #(
   parameter int PSC_W         = 3,
   parameter bit BLOCK_UNDIV   = 1'b1
) (
   input  logic [PSC_W-1:0] psc,
   input  logic             evt,
   output logic             evt_ok
);

   generate
      if (BLOCK_UNDIV) begin : g_block
         // R7: undivided neighbour clock gives no capture trigger
         assign evt_ok = evt && (psc != '0);
      end else begin : g_pass
         logic unused_psc;
         assign unused_psc = ^psc;
         assign evt_ok     = evt;
      end
   endgenerate

endmodule

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/tcc_gr_unit.sv
module tcc_gr_unit
   import tcc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] field,
   input  logic [FIELD_W-1:0] field_new,
   input  logic               field_wr,
   input  logic               gr_wr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic [CNT_W-1:0]   cnt_val,
   input  logic               cnt_en,
   input  logic               nb_ok,
   input  logic               pin_in,
   output logic [CNT_W-1:0]   gr_q,
   output logic               pin_out,
   output logic               pin_oe
);

   tcc_mode_t mode;
   tcc_mode_t mode_new;
   logic      rise, fall;
   logic      cap_pin, cap_nb, cap;
   logic      match;

   assign mode     = tcc_decode(field);
   assign mode_new = tcc_decode(field_new);

   tcc_pin_sync #(.STAGES(STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_in),
      .rise (rise),
      .fall (fall)
   );

   // R5: edge selection
   always_comb begin
      cap_pin = 1'b0;
      if (mode.src == SRC_PIN) begin
         unique case (mode.edge_sel)
            2'b00:   cap_pin = rise;
            2'b01:   cap_pin = fall;
            default: cap_pin = rise | fall;
         endcase
      end
   end

   // R6: neighbour-sourced capture
   assign cap_nb = (mode.src == SRC_NB) && nb_ok;
   assign cap    = cap_pin | cap_nb;

   // R8: capture has priority over a software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gr_q <= '0;
      else if (cap)
         gr_q <= cnt_val;
      else if (gr_wr)
         gr_q <= wr_data;
   end

   assign match = (mode.src == SRC_CMP) && cnt_en && (cnt_val == gr_q);

   // R2, R4, R9: pin level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_out <= 1'b0;
      else if (field_wr && (mode_new.src == SRC_CMP))
         pin_out <= mode_new.init_lvl;
      else if (match) begin
         unique case (mode.act)
            ACT_LOW:  pin_out <= 1'b0;
            ACT_HIGH: pin_out <= 1'b1;
            ACT_TOG:  pin_out <= ~pin_out;
            default:  pin_out <= pin_out;
         endcase
      end
   end

   // R3
   assign pin_oe = (mode.src == SRC_CMP) && (mode.act != ACT_NONE);

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
   import tcc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit BLOCK_UNDIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_en,
   input  logic [PSC_W-1:0] nb_psc,
   input  logic             nb_cnt_evt,
   input  logic             pin_a_in,
   input  logic             pin_b_in,
   output logic [7:0]       ctrl_q,
   output logic [CNT_W-1:0] gr_a,
   output logic [CNT_W-1:0] gr_b,
   output logic             pin_a_out,
   output logic             pin_a_oe,
   output logic             pin_b_out,
   output logic             pin_b_oe
);

   localparam logic [1:0] SEL_CTRL = 2'd0;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("CNT_W must be at least the control register width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PSC_W < 1) begin : g_bad_psc
         $error("PSC_W must be at least 1");
      end
   endgenerate

   logic             ctrl_wr;
   logic             nb_ok;
   logic [CNT_W-1:0] gr_v   [NUM_GR];
   logic [NUM_GR-1:0] pin_o, pin_e, pin_i;

   assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
   assign pin_i   = {pin_b_in, pin_a_in};

   // R1
   tcc_ctrl_reg #(.W(CTRL_W)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (ctrl_wr),
      .din  (wr_data[CTRL_W-1:0]),
      .q    (ctrl_q)
   );

   tcc_nb_gate #(.PSC_W(PSC_W), .BLOCK_UNDIV(BLOCK_UNDIV)) u_nb (
      .psc   (nb_psc),
      .evt   (nb_cnt_evt),
      .evt_ok(nb_ok)
   );

   generate
      for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
         logic gr_wr;
         assign gr_wr = wr_en && (wr_sel == 2'(g + 1));

         tcc_gr_unit #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .field    (ctrl_q[FIELD_W*g +: FIELD_W]),
            .field_new(wr_data[FIELD_W*g +: FIELD_W]),
            .field_wr (ctrl_wr),
            .gr_wr    (gr_wr),
            .wr_data  (wr_data),
            .cnt_val  (cnt_val),
            .cnt_en   (cnt_en),
            .nb_ok    (nb_ok),
            .pin_in   (pin_i[g]),
            .gr_q     (gr_v[g]),
            .pin_out  (pin_o[g]),
            .pin_oe   (pin_e[g])
         );
      end
   endgenerate

   assign gr_a      = gr_v[0];
   assign gr_b      = gr_v[1];
   assign pin_a_out = pin_o[0];
   assign pin_a_oe  = pin_e[0];
   assign pin_b_out = pin_o[1];
   assign pin_b_oe  = pin_e[1];

endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] cnt_val,
   input logic             cnt_en,
   input logic [PSC_W-1:0] nb_psc,
   input logic             nb_cnt_evt,
   input logic [7:0]       ctrl_q,
   input logic [CNT_W-1:0] gr_a,
   input logic [CNT_W-1:0] gr_b,
   input logic             pin_a_out,
   input logic             pin_a_oe,
   input logic             pin_b_out,
   input logic             pin_b_oe
);

   logic ctl_w, a_w, b_w;
   assign ctl_w = wr_en && (wr_sel == 2'd0);
   assign a_w   = wr_en && (wr_sel == 2'd1);
   assign b_w   = wr_en && (wr_sel == 2'd2);

   p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_w |=> ctrl_q == $past(wr_data[7:0]));

   p_entry_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && !wr_data[3]) |=> pin_a_out == $past(wr_data[2]));

   p_oe_off_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[3] |-> !pin_a_oe);

   p_oe_off_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[7] |-> !pin_b_oe);

   p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[3] && ctrl_q[1:0] == 2'b11 && cnt_en && cnt_val == gr_a && !ctl_w)
      |=> pin_a_out != $past(pin_a_out));

   p_nb_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[7:6] == 2'b11 && nb_cnt_evt && nb_psc != '0) |=> gr_b == $past(cnt_val));

   p_nb_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[7:6] == 2'b11 && nb_psc == '0 && !b_w) |=> $stable(gr_b));

   p_cap_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3:2] == 2'b11 && nb_cnt_evt && nb_psc != '0 && a_w) |=> gr_a == $past(cnt_val));

   p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3] && !ctl_w) |=> $stable(pin_a_out));

   p_hold_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[7] && !ctl_w) |=> $stable(pin_b_out));

endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .cnt_val   (cnt_val),
   .cnt_en    (cnt_en),
   .nb_psc    (nb_psc),
   .nb_cnt_evt(nb_cnt_evt),
   .ctrl_q    (ctrl_q),
   .gr_a      (gr_a),
   .gr_b      (gr_b),
   .pin_a_out (pin_a_out),
   .pin_a_oe  (pin_a_oe),
   .pin_b_out (pin_b_out),
   .pin_b_oe  (pin_b_oe)
);

// File: tb/tcc_channel_bench.sv
`timescale 1ns/1ps
module tcc_channel_bench;

   localparam int CNT_W = 16;
   localparam int PSC_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_sel = 2'd3;
   logic [CNT_W-1:0] wr_data = '0;
   logic [CNT_W-1:0] cnt_val = '0;
   logic             cnt_en = 1'b0;
   logic [PSC_W-1:0] nb_psc = '0;
   logic             nb_cnt_evt = 1'b0;
   logic             pin_a_in = 1'b0;
   logic             pin_b_in = 1'b0;
   logic [7:0]       ctrl_q;
   logic [CNT_W-1:0] gr_a, gr_b;
   logic             pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;

   tcc_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tcc_channel (.*);

   always #10 clk = ~clk;

   typedef enum int {S_CTRL, S_GRA, S_GRB, S_PA, S_OEA, S_PB, S_OEB} sig_e;
   typedef struct {
      string            req;
      sig_e             sig;
      logic [CNT_W-1:0] exp;
   } item_t;

   item_t q[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;

   function automatic logic [CNT_W-1:0] observe(sig_e s);
      case (s)
         S_CTRL:  return CNT_W'(ctrl_q);
         S_GRA:   return gr_a;
         S_GRB:   return gr_b;
         S_PA:    return CNT_W'(pin_a_out);
         S_OEA:   return CNT_W'(pin_a_oe);
         S_PB:    return CNT_W'(pin_b_out);
         default: return CNT_W'(pin_b_oe);
      endcase
   endfunction

   // monitor: compares queued expectations away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            item_t it;
            logic [CNT_W-1:0] act;
            it  = q.pop_front();
            act = observe(it.sig);
            n_chk++;
            if (act !== it.exp) begin
               n_err++;
               $display("FAIL %s sig=%s actual=%h expected=%h", it.req, it.sig.name(), act, it.exp);
            end
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic cycn(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic exp_item(string r, sig_e s, logic [CNT_W-1:0] v);
      q.push_back('{req: r, sig: s, exp: v});
   endtask

   task automatic wr(logic [1:0] sel, logic [CNT_W-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      cyc();
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   initial begin
      cycn(3);
      // R1, R10: reset state
      exp_item("R1", S_CTRL, 16'h0);
      exp_item("R10", S_GRA, 16'h0);
      exp_item("R10", S_GRB, 16'h0);
      exp_item("R3", S_OEA, 16'h0);
      exp_item("R2", S_PA, 16'h0);
      rst_n = 1'b1;
      cyc();

      // R10: general register writes
      wr(2'd1, 16'h0010);
      exp_item("R10", S_GRA, 16'h0010);
      wr(2'd2, 16'h0020);
      exp_item("R10", S_GRB, 16'h0020);

      // R1, R2, R3: A=0101 (start 1, drive 0), B=0011 (start 0, invert)
      wr(2'd0, 16'h0035);
      exp_item("R1", S_CTRL, 16'h0035);
      exp_item("R2", S_PA, 16'h1);
      exp_item("R3", S_OEA, 16'h1);
      exp_item("R2", S_PB, 16'h0);
      exp_item("R3", S_OEB, 16'h1);

      // R4: equal but no cnt_en
      cnt_val = 16'h0010; cnt_en = 1'b0;
      cyc();
      exp_item("R4", S_PA, 16'h1);
      cnt_en = 1'b1;
      cyc();
      exp_item("R4", S_PA, 16'h0);
      exp_item("R4", S_PB, 16'h0);

      // R4: invert twice
      cnt_val = 16'h0020;
      cyc();
      exp_item("R4", S_PB, 16'h1);
      cyc();
      exp_item("R4", S_PB, 16'h0);

      // R2, R3: A=0010 (start 0, drive 1), B=0100 (start 1, disabled)
      cnt_val = 16'h0000;
      wr(2'd0, 16'h0042);
      exp_item("R2", S_PA, 16'h0);
      exp_item("R3", S_OEA, 16'h1);
      exp_item("R2", S_PB, 16'h1);
      exp_item("R3", S_OEB, 16'h0);
      cnt_val = 16'h0010;
      cyc();
      exp_item("R4", S_PA, 16'h1);
      cnt_val = 16'h0020;
      cyc();
      exp_item("R4", S_PB, 16'h1);

      // R5, R9: A rising (1000), B falling (1001)
      cnt_val = 16'h0000;
      wr(2'd0, 16'h0098);
      exp_item("R3", S_OEA, 16'h0);
      exp_item("R3", S_OEB, 16'h0);
      exp_item("R9", S_PA, 16'h1);
      cnt_val = 16'h1234; pin_a_in = 1'b1;
      cycn(2);
      exp_item("R5", S_GRA, 16'h0010);
      cyc();
      exp_item("R5", S_GRA, 16'h1234);
      exp_item("R9", S_PA, 16'h1);
      exp_item("R9", S_PB, 16'h1);
      cnt_val = 16'h2222; pin_a_in = 1'b0; pin_b_in = 1'b1;
      cycn(4);
      exp_item("R5", S_GRA, 16'h1234);
      exp_item("R5", S_GRB, 16'h0020);
      cnt_val = 16'h3333; pin_b_in = 1'b0;
      cycn(3);
      exp_item("R5", S_GRB, 16'h3333);

      // R5: both edges on A (1010)
      wr(2'd0, 16'h009A);
      cnt_val = 16'h4444; pin_a_in = 1'b1;
      cycn(3);
      exp_item("R5", S_GRA, 16'h4444);
      cnt_val = 16'h5555; pin_a_in = 1'b0;
      cycn(3);
      exp_item("R5", S_GRA, 16'h5555);

      // R6, R7: neighbour source, A=1100, B=1111
      wr(2'd0, 16'h00FC);
      nb_psc = 3'b000; nb_cnt_evt = 1'b1; cnt_val = 16'h6666;
      cyc();
      exp_item("R7", S_GRA, 16'h5555);
      exp_item("R7", S_GRB, 16'h3333);
      nb_psc = 3'b001;
      cyc();
      exp_item("R6", S_GRA, 16'h6666);
      exp_item("R6", S_GRB, 16'h6666);
      nb_cnt_evt = 1'b0; cnt_val = 16'h7777;
      cyc();
      exp_item("R6", S_GRA, 16'h6666);

      // R8: capture and write on the same edge
      nb_cnt_evt = 1'b1; cnt_val = 16'h8888;
      wr(2'd1, 16'h0ABC);
      exp_item("R8", S_GRA, 16'h8888);
      nb_cnt_evt = 1'b0;
      wr(2'd2, 16'h0ABC);
      exp_item("R10", S_GRB, 16'h0ABC);
      exp_item("R9", S_PA, 16'h1);

      @(negedge clk);
      #1;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule